// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block produces the 16x oversampling strobe that a UART receiver and transmitter use to time their bit cells. It counts cycles of a chosen source: the local peripheral clock, or one of two external sources. The external sources arrive as single-cycle pulses that are already synchronised to the local clock. Each sample period lasts the integer divisor plus one source cycles.

A 16-bit slot mask adds a fractional correction. The sixteen sample periods of one bit are numbered 0 to 15, and period i is stretched by one extra source cycle when mask bit i is set. The average divisor therefore has a resolution of one sixteenth. The divisor is normally chosen as source frequency / (16 × baud) − 1. As an example, a 66.5 MHz source at 115200 baud gives an integer part of 35, and a mask with a single set bit adds the remaining fraction.

Whenever the divisor or the mask changes, the count and the period index restart from zero. This keeps a new setting from finishing a period that was begun under the old one.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held the tick output is 0. After release with peripheral source selected, the first tick is seen div+1+mask[0] cycles after the first active edge.
- R2: The tick is a single-cycle pulse: with divisor ≥ 1 it is never high in two consecutive cycles.
- R3: With the mask all zero, ticks are spaced exactly div+1 source cycles apart, including the largest divisor the register holds.
- R4: Sample period i (i = 0..15, counted from the last restart) lasts div+2 source cycles when mask bit i is 1 and div+1 otherwise. The index wraps from 15 to 0.
- R5: Any 16 consecutive periods starting at index 0 take 16×(div+1)+popcount(mask) source cycles.
- R6: Select field encoding: bit 0 = 0 selects the peripheral clock, in which every clock cycle counts (codes 00 and 10). Code 01 counts pulses on external source 0 and code 11 counts pulses on external source 1. Pulses on the unselected source are ignored, and a tick only follows a cycle in which the selected source was active.
- R7: A change in the divisor or the mask value clears the count and the period index at the next edge, and no tick is produced in the cycle that follows. Counting then resumes from period 0 under the new values.
- R8: With divisor 35 and mask 0x0001 (the 66.5 MHz / 115200 setting), one full bit of 16 ticks spans 577 source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral (local) clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Source select: x0 peripheral, 01 external 0, 11 external 1 |
| ext0_pulse | input | 1 | One-cycle pulse per cycle of external source 0 (synchronised) |
| ext1_pulse | input | 1 | One-cycle pulse per cycle of external source 1 (synchronised) |
| div_val | input | DIV_W | Integer divisor |
| slot_mask | input | OVS | Fractional stretch mask, bit i stretches period i |
| tick | output | 1 | One-cycle 16x sample enable |

## Verification
The bench builds the block with DIV_W = 8, OVS = 16 and the external sources enabled. The 8-bit divisor puts the largest divisor, 255, within a few thousand cycles. At that value the stretched period of 257 needs the counter's extra bit, so the overflow boundary is exercised. Sixteen slots keep a full index wrap, and the 16-period sum, short enough to repeat for several masks. The external-source path is driven by pulse trains of different rates on the two inputs, which makes a wrongly selected source visible in the tick timing.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

   typedef enum logic [1:0] {
      SRC_LOCAL_A = 2'b00,
      SRC_EXT_0   = 2'b01,
      SRC_LOCAL_B = 2'b10,
      SRC_EXT_1   = 2'b11
   } src_code_e;

   function automatic logic uses_ext(input logic [1:0] code);
      return code[0];
   endfunction

   function automatic logic ext_is_one(input logic [1:0] code);
      return code[1];
   endfunction

endpackage

// File: rtl/fbg_src_sel.sv
module fbg_src_sel #(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic [1:0] clk_sel,
   input  logic       ext0_pulse,
   input  logic       ext1_pulse,
   output logic       src_en
);
   import fbg_pkg::*;

   generate
      if (HAS_EXT) begin : g_ext
         always_comb begin
            if (!uses_ext(clk_sel))
               src_en = 1'b1;
            else if (ext_is_one(clk_sel))
               src_en = ext1_pulse;
            else
               src_en = ext0_pulse;
         end
      end else begin : g_local_only
         logic unused_sel;
         assign unused_sel = ^{clk_sel, ext0_pulse, ext1_pulse};
         assign src_en = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/fbg_reload_det.sv
module fbg_reload_det #(
   parameter int DIV_W = 16,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic [OVS-1:0]   slot_mask,
   output logic [DIV_W-1:0] div_q,
   output logic [OVS-1:0]   slot_q,
   output logic             restart
);

   // Shadow copies are loaded every cycle, including during reset, so
   // leaving reset never looks like a register change.
   always_ff @(posedge clk) begin
      div_q  <= div_val;
      slot_q <= slot_mask;
   end

   assign restart = rst_n && ((div_val != div_q) || (slot_mask != slot_q));

   AST_SHADOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (div_q == $past(div_val) && slot_q == $past(slot_mask))); // R7

endmodule

// File: rtl/fbg_div_core.sv
module fbg_div_core #(
   parameter int DIV_W = 16,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_en,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_q,
   input  logic [OVS-1:0]   slot_q,
   output logic             tick
);
   localparam int IDX_W = $clog2(OVS);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] last;

   // Final count of the current period: divisor, plus one if stretched.
   assign last = {1'b0, div_q} + CNT_W'(slot_q[idx]);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt  <= '0;
         idx  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (src_en) begin
            if (cnt == last) begin
               cnt  <= '0;
               idx  <= idx + 1'b1;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt <= last)); // R3

   AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (idx == IDX_W'($past(idx) + 1'b1))); // R4

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_q != '0 && !restart) |=> !tick); // R2

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!tick && cnt == '0 && idx == '0)); // R7

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int DIV_W   = 16,
   parameter int OVS     = 16,
   parameter bit HAS_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       clk_sel,
   input  logic             ext0_pulse,
   input  logic             ext1_pulse,
   input  logic [DIV_W-1:0] div_val,
   input  logic [OVS-1:0]   slot_mask,
   output logic             tick
);

   generate
      if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 2");
      end
      if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
         $error("DIV_W must lie in 1..30");
      end
   endgenerate

   logic             src_en;
   logic             restart;
   logic [DIV_W-1:0] div_q;
   logic [OVS-1:0]   slot_q;

   fbg_src_sel #(.HAS_EXT(HAS_EXT)) u_sel (
      .clk_sel    (clk_sel),
      .ext0_pulse (ext0_pulse),
      .ext1_pulse (ext1_pulse),
      .src_en     (src_en)
   );

   fbg_reload_det #(.DIV_W(DIV_W), .OVS(OVS)) u_reload (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_val   (div_val),
      .slot_mask (slot_mask),
      .div_q     (div_q),
      .slot_q    (slot_q),
      .restart   (restart)
   );

   fbg_div_core #(.DIV_W(DIV_W), .OVS(OVS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_en  (src_en),
      .restart (restart),
      .div_q   (div_q),
      .slot_q  (slot_q),
      .tick    (tick)
   );

   AST_TICK_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(src_en)); // R6

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
   localparam int DIV_W = 8;
   localparam int OVS   = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       clk_sel = 2'b00;
   logic             ext0_pulse = 1'b0;
   logic             ext1_pulse = 1'b0;
   logic [DIV_W-1:0] div_val = 8'd3;
   logic [OVS-1:0]   slot_mask = '0;
   logic             tick;

   int    tests = 0;
   int    fails = 0;
   string req = "R1";
   bit    done = 0;
   bit    ext0_on = 1'b1;
   int    ext_ctr = 0;

   always #10 clk = ~clk;

   frac_baud_gen #(.DIV_W(DIV_W), .OVS(OVS), .HAS_EXT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext0_pulse(ext0_pulse),
      .ext1_pulse(ext1_pulse), .div_val(div_val), .slot_mask(slot_mask), .tick(tick)
   );

   // External pulse trains: source 0 every 3 cycles, source 1 every 5.
   always @(negedge clk) begin
      ext_ctr++;
      ext0_pulse = ext0_on && (ext_ctr % 3 == 0);
      ext1_pulse = (ext_ctr % 5 == 0);
   end

   // Behavioural reference, evaluated on each rising edge.
   int m_div, m_slot, m_cnt, m_idx;
   bit m_exp = 0;
   always @(posedge clk) begin
      bit en;
      int len;
      if (!rst_n || div_val != m_div[DIV_W-1:0] || slot_mask != m_slot[OVS-1:0]) begin
         m_div = div_val; m_slot = slot_mask; m_cnt = 0; m_idx = 0; m_exp = 0;
      end else begin
         m_exp = 0;
         if (clk_sel[0] == 1'b0) en = 1;
         else if (clk_sel[1]) en = ext1_pulse;
         else en = ext0_pulse;
         if (en) begin
            len = m_div + 1 + ((m_slot >> m_idx) & 1);
            if (m_cnt == len - 1) begin
               m_cnt = 0; m_idx = (m_idx + 1) % OVS; m_exp = 1;
            end else m_cnt++;
         end
      end
   end

   task automatic check(input bit ok, input string r, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, plus the pulse-width rule (R2).
   bit prev_tick = 0;
   always @(negedge clk) begin
      if (!done) begin
         check(tick === m_exp, req, int'(tick), int'(m_exp));
         if (rst_n && div_val != 0 && prev_tick && tick)
            check(1'b0, "R2", 1, 0);
         prev_tick = tick;
      end
   end

   task automatic set_cfg(input logic [1:0] s, input int d, input int m);
      @(negedge clk);
      clk_sel = s; div_val = DIV_W'(d); slot_mask = OVS'(m);
   endtask

   task automatic measure(input int n, output int cyc);
      int seen = 0;
      cyc = 0;
      while (seen < n && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (tick) seen++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c;
      repeat (4) @(negedge clk);
      check(tick === 1'b0, "R1", int'(tick), 0);
      rst_n = 1'b1;
      measure(1, c);
      check(c == 4, "R1", c, 4);

      req = "R3";
      set_cfg(2'b00, 5, 0);
      measure(16, c);
      check(c == 16*6 + 1, "R3", c, 97);
      set_cfg(2'b00, 255, 0);
      measure(2, c);
      check(c == 2*256 + 1, "R3", c, 513);
      set_cfg(2'b00, 255, 16'hFFFF);
      measure(16, c);
      check(c == 16*257 + 1, "R3", c, 4113);

      req = "R4";
      set_cfg(2'b00, 2, 16'h0005);
      measure(1, c); check(c == 5, "R4", c, 5);
      measure(1, c); check(c == 3, "R4", c, 3);
      measure(1, c); check(c == 4, "R4", c, 4);
      measure(1, c); check(c == 3, "R4", c, 3);
      set_cfg(2'b00, 2, 16'h8000);
      measure(15, c); check(c == 15*3 + 1, "R4", c, 46);
      measure(1, c);  check(c == 4, "R4", c, 4);
      measure(1, c);  check(c == 3, "R4", c, 3);

      req = "R5";
      set_cfg(2'b00, 1, 16'hFFFF);
      measure(16, c); check(c == 16*3 + 1, "R5", c, 49);
      set_cfg(2'b00, 2, 16'h8001);
      measure(32, c); check(c == 2*50 + 1, "R5", c, 101);

      req = "R8";
      set_cfg(2'b00, 35, 16'h0001);
      measure(16, c); check(c == 577 + 1, "R8", c, 578);

      req = "R6";
      set_cfg(2'b10, 3, 0);
      measure(16, c); check(c == 16*4 + 1, "R6", c, 65);
      set_cfg(2'b01, 1, 0);
      measure(8, c); check(c > 8*6 - 6 && c <= 8*6 + 3, "R6", c, 48);
      set_cfg(2'b11, 1, 0);
      measure(8, c); check(c > 8*10 - 10 && c <= 8*10 + 5, "R6", c, 80);
      ext0_on = 1'b0;
      set_cfg(2'b01, 0, 0);
      measure(1, c); check(c == 20000, "R6", c, 20000);
      ext0_on = 1'b1;

      req = "R7";
      set_cfg(2'b00, 9, 0);
      repeat (6) @(negedge clk);
      set_cfg(2'b00, 9, 16'h0001);
      @(negedge clk);
      check(tick === 1'b0, "R7", int'(tick), 0);
      measure(1, c); check(c == 11, "R7", c, 11);
      set_cfg(2'b00, 4, 16'h0001);
      measure(1, c); check(c == 7, "R7", c, 7);

      req = "R2";
      set_cfg(2'b00, 1, 0);
      repeat (40) @(negedge clk);
      set_cfg(2'b00, 0, 0);
      measure(10, c); check(c == 11, "R2", c, 11);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule